// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block turns parallel characters into an asynchronous serial stream. A host places a character on an 8-bit bus and pulses an active-low load strobe. The character lands in a holding register. When the serial shifter is free, the character moves into it and is sent as a start bit, 5 to 8 data bits, an optional parity bit and a stop period of one, one and a half or two bit times. The holding register is free again as soon as the hand-off happens, so the host can queue the next character while the current one is still on the line. Back-to-back characters then leave with no idle gap between them.

The block runs from a clock at sixteen times the bit rate, and every bit lasts sixteen of its cycles. The character format is held in a small control register. That register is written from dedicated inputs while a control-load input is high. The load strobe may come from another timing domain, so it is resynchronised before it marks the holding register full. Two flags tell the host whether the holding register and the shifter are empty. An asynchronous master reset returns the line to idle-high and clears the format register.

Top module: `uart_tx_buffered`

## Requirements
- R1: While and after master reset, `txd`, `hold_empty` and `shift_empty` are all high. The control register resets to all zeros: 5 data bits, parity enabled, odd parity, one stop bit.
- R2: The bus is captured while `load_n` is low. `hold_empty` falls at the third rising clock edge after the rising (trailing) edge of `load_n`.
- R3: When the shifter is idle, the holding register is moved into it at the edge after the holding register becomes full. At that edge `hold_empty` returns high, `shift_empty` falls and `txd` drops low for the start bit.
- R4: A frame is a low start bit followed by the data bits, least significant first. Each bit lasts 16 clock cycles. `word_sel` gives the word length: 0 for 5 bits, 1 for 6, 2 for 7 and 3 for 8. The line is high whenever `shift_empty` is high.
- R5: With `par_off` low, a parity bit follows the data. It is computed over the selected data bits only: even when `par_even` is 1, odd when it is 0. With `par_off` high, the stop period follows the last data bit directly.
- R6: The stop period is high for 16 cycles when `stop_two` is 0. It lasts 32 cycles when `stop_two` is 1, and 24 cycles when `stop_two` is 1 with 5-bit words. `shift_empty` rises at the end of the stop period.
- R7: If the holding register is full when a stop period ends, the next start bit begins on the very next cycle, and `shift_empty` stays low.
- R8: The format inputs (`word_sel`, `par_off`, `par_even`, `stop_two`) are latched only while `ctl_load` is high. At other times changes on them do not alter the frames sent.
- R9: Master reset asserted in the middle of a frame forces `txd` high at once, sets both flags high and abandons the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk16 | input | 1 | Clock at 16 times the bit rate |
| rst | input | 1 | Asynchronous master reset, active high |
| tx_bus | input | 8 | Parallel character to send |
| load_n | input | 1 | Holding-register load strobe, active low, latched on its rising edge |
| ctl_load | input | 1 | Loads the format inputs into the control register while high |
| word_sel | input | 2 | Word length select: 0..3 gives 5..8 data bits |
| par_off | input | 1 | High disables the parity bit |
| par_even | input | 1 | High selects even parity, low selects odd |
| stop_two | input | 1 | High selects two stop bits (1.5 with 5-bit words) |
| txd | output | 1 | Serial data out, idle high |
| hold_empty | output | 1 | Holding register may be reloaded |
| shift_empty | output | 1 | Shifter has finished the last character, stop period included |

## Verification
The bench samples every bit slot at its centre and checks the exact cycle in which the stop period ends. A stop timer that used 32 cycles for 5-bit words, or left out the half bit, shifts the rise of `shift_empty` by 8 cycles and is caught. Parity is checked in both senses on words shorter than eight bits. A design that included unsent high bits in the sum, or swapped even and odd, shows a wrong parity slot. A queued second character must start on the cycle after the first stop ends; an extra idle cycle in the hand-off shows as `txd` still high there. The bench also changes the format inputs with `ctl_load` low and asserts reset in the middle of a frame. These catch a control register that follows its inputs, and a reset that leaves the line low or the frame running.

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered #(
  parameter int OVS = 16
) (
  input  logic       clk16,
  input  logic       rst,
  input  logic [7:0] tx_bus,
  input  logic       load_n,
  input  logic       ctl_load,
  input  logic [1:0] word_sel,
  input  logic       par_off,
  input  logic       par_even,
  input  logic       stop_two,
  output logic       txd,
  output logic       hold_empty,
  output logic       shift_empty
);
  localparam int CW = $clog2(2 * OVS + 1);
  localparam logic [CW-1:0] LEN_BIT  = CW'(OVS);
  localparam logic [CW-1:0] LEN_S15  = CW'((OVS * 3) / 2);
  localparam logic [CW-1:0] LEN_S2   = CW'(2 * OVS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  logic [1:0]    wsel_q;
  logic          poff_q, peven_q, stwo_q;
  logic          ld_s1, ld_s2, ld_s3;
  logic [7:0]    hold_q;
  logic          full_q;
  logic [7:0]    sh_q;
  logic          par_q;
  logic [2:0]    bidx_q;
  logic [CW-1:0] cnt_q;
  state_t        state_q;

  logic          strobe_rise;
  logic [2:0]    last_idx;
  logic [2:0]    bidx_nxt;
  logic [CW-1:0] stop_len;
  logic [CW-1:0] cur_len;
  logic          at_end;
  logic          take;
  logic [7:0]    masked;
  logic          ones;

  assign strobe_rise = ld_s2 & ~ld_s3;
  assign last_idx    = {1'b0, wsel_q} + 3'd4;
  assign bidx_nxt    = bidx_q + 3'd1;
  assign stop_len    = !stwo_q ? LEN_BIT : (wsel_q == 2'd0 ? LEN_S15 : LEN_S2);
  assign cur_len     = (state_q == S_STOP) ? stop_len : LEN_BIT;
  assign at_end      = (cnt_q == cur_len - 1'b1);
  assign take        = full_q && (state_q == S_IDLE || (state_q == S_STOP && at_end));
  assign masked      = hold_q & (8'hFF >> (2'd3 - wsel_q));
  assign ones        = ^masked;
  assign hold_empty  = ~full_q;

  always_ff @(posedge clk16 or posedge rst) begin
    if (rst) begin
      wsel_q  <= 2'd0;
      poff_q  <= 1'b0;
      peven_q <= 1'b0;
      stwo_q  <= 1'b0;
    end else if (ctl_load) begin
      wsel_q  <= word_sel;
      poff_q  <= par_off;
      peven_q <= par_even;
      stwo_q  <= stop_two;
    end
  end

  always_ff @(posedge clk16 or posedge rst) begin
    if (rst) begin
      ld_s1 <= 1'b1;
      ld_s2 <= 1'b1;
      ld_s3 <= 1'b1;
    end else begin
      ld_s1 <= load_n;
      ld_s2 <= ld_s1;
      ld_s3 <= ld_s2;
    end
  end

  always_ff @(posedge clk16 or posedge rst) begin
    if (rst) hold_q <= 8'h00;
    else if (!load_n) hold_q <= tx_bus;
  end

  always_ff @(posedge clk16 or posedge rst) begin
    if (rst) full_q <= 1'b0;
    else if (strobe_rise) full_q <= 1'b1;
    else if (take) full_q <= 1'b0;
  end

  always_ff @(posedge clk16 or posedge rst) begin
    if (rst) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      bidx_q      <= 3'd0;
      sh_q        <= 8'h00;
      par_q       <= 1'b0;
      txd         <= 1'b1;
      shift_empty <= 1'b1;
    end else if (take) begin
      state_q     <= S_START;
      cnt_q       <= '0;
      bidx_q      <= 3'd0;
      sh_q        <= masked;
      par_q       <= peven_q ? ones : ~ones;
      txd         <= 1'b0;
      shift_empty <= 1'b0;
    end else if (state_q != S_IDLE) begin
      if (!at_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        case (state_q)
          S_START: begin
            state_q <= S_DATA;
            txd     <= sh_q[0];
          end
          S_DATA: begin
            if (bidx_q == last_idx) begin
              if (poff_q) begin
                state_q <= S_STOP;
                txd     <= 1'b1;
              end else begin
                state_q <= S_PAR;
                txd     <= par_q;
              end
            end else begin
              bidx_q <= bidx_nxt;
              txd    <= sh_q[bidx_nxt];
            end
          end
          S_PAR: begin
            state_q <= S_STOP;
            txd     <= 1'b1;
          end
          default: begin
            state_q     <= S_IDLE;
            shift_empty <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_fill_after_strobe_R2: assert property (@(posedge clk16) disable iff (rst)
    $fell(hold_empty) |-> $past(ld_s2 && !ld_s3));

  assert_start_low_R3: assert property (@(posedge clk16) disable iff (rst)
    $fell(shift_empty) |-> !txd);

  assert_refill_busy_R3: assert property (@(posedge clk16) disable iff (rst)
    $rose(hold_empty) |-> (!shift_empty && !txd));

  assert_idle_high_R4: assert property (@(posedge clk16) disable iff (rst)
    shift_empty |-> txd);

  assert_bit_steady_R4: assert property (@(posedge clk16) disable iff (rst)
    (state_q != S_IDLE && cnt_q != '0) |-> $stable(txd));

  assert_done_after_stop_R6: assert property (@(posedge clk16) disable iff (rst)
    $rose(shift_empty) |-> $past(state_q) == S_STOP);

endmodule

// File: tb/uart_tx_buffered_test.sv
module uart_tx_buffered_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_bus = 8'h00;
  logic       load_n = 1'b1;
  logic       ctl_load = 1'b0;
  logic [1:0] word_sel = 2'd0;
  logic       par_off = 1'b0;
  logic       par_even = 1'b0;
  logic       stop_two = 1'b0;
  logic       txd, hold_empty, shift_empty;

  int vectors = 0;
  int miscompares = 0;

  always #(PERIOD / 2) clk = ~clk;

  uart_tx_buffered uut (
    .clk16(clk), .rst(rst), .tx_bus(tx_bus), .load_n(load_n),
    .ctl_load(ctl_load), .word_sel(word_sel), .par_off(par_off),
    .par_even(par_even), .stop_two(stop_two),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input bit even);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    return even ? x : ~x;
  endfunction

  task automatic set_ctrl(input int nb, input bit poff, input bit peven, input bit stwo);
    @(negedge clk);
    word_sel = 2'(nb - 5);
    par_off = poff;
    par_even = peven;
    stop_two = stwo;
    ctl_load = 1'b1;
    @(negedge clk);
    ctl_load = 1'b0;
  endtask

  // returns at the fourth negedge after the strobe's rising edge
  task automatic write_and_start(input logic [7:0] d, input string tag);
    @(negedge clk);
    tx_bus = d;
    load_n = 1'b0;
    repeat (2) @(negedge clk);
    load_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold_empty == 1'b0, {"R2 holding full ", tag}, int'(hold_empty), 0);
    @(negedge clk);
    chk(txd == 1'b0, {"R3 start bit ", tag}, int'(txd), 0);
    chk(hold_empty == 1'b1, {"R3 holding freed ", tag}, int'(hold_empty), 1);
    chk(shift_empty == 1'b0, {"R3 shifter busy ", tag}, int'(shift_empty), 0);
  endtask

  // entered at the first cycle of the start bit
  task automatic check_body(input logic [7:0] d, input int nb, input bit poff,
                            input bit peven, input bit stwo, input bit chain,
                            input string tag);
    int s = 1 + nb + (poff ? 0 : 1);
    int stop_len = stwo ? ((nb == 5) ? 24 : 32) : 16;
    logic p = par_of(d, nb, peven);
    repeat (8) @(negedge clk);
    for (int j = 0; j < s; j++) begin
      logic e;
      if (j > 0) repeat (16) @(negedge clk);
      if (j == 0) e = 1'b0;
      else if (j <= nb) e = d[j-1];
      else e = p;
      if (j > nb) chk(txd == e, {"R5 parity slot ", tag}, int'(txd), int'(e));
      else chk(txd == e, {"R4 bit slot ", tag}, int'(txd), int'(e));
    end
    repeat (stop_len + 7) @(negedge clk);
    chk(txd == 1'b1, {"R6 last stop cycle high ", tag}, int'(txd), 1);
    chk(shift_empty == 1'b0, {"R6 still busy in stop ", tag}, int'(shift_empty), 0);
    @(negedge clk);
    if (chain) begin
      chk(txd == 1'b0, {"R7 next start without gap ", tag}, int'(txd), 0);
      chk(shift_empty == 1'b0, {"R7 shifter stays busy ", tag}, int'(shift_empty), 0);
    end else begin
      chk(shift_empty == 1'b1, {"R6 shifter empty after stop ", tag}, int'(shift_empty), 1);
      chk(txd == 1'b1, {"R6 idle line ", tag}, int'(txd), 1);
    end
  endtask

  task automatic frame(input logic [7:0] d, input int nb, input bit poff,
                       input bit peven, input bit stwo, input string tag);
    write_and_start(d, tag);
    check_body(d, nb, poff, peven, stwo, 1'b0, tag);
    repeat (5) @(negedge clk);
  endtask

  task automatic test_reset_state();
    chk(txd == 1'b1, "R1 txd in reset", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1 hold_empty in reset", int'(hold_empty), 1);
    chk(shift_empty == 1'b1, "R1 shift_empty in reset", int'(shift_empty), 1);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && shift_empty == 1'b1, "R1 idle after reset", int'(txd), 1);
  endtask

  task automatic test_default_format();
    frame(8'hB3, 5, 1'b0, 1'b0, 1'b0, "R1 default 5-bit odd one stop");
  endtask

  task automatic test_formats();
    set_ctrl(8, 1'b0, 1'b1, 1'b0);
    frame(8'hA5, 8, 1'b0, 1'b1, 1'b0, "R4 8-bit even");
    set_ctrl(7, 1'b1, 1'b0, 1'b1);
    frame(8'hD6, 7, 1'b1, 1'b0, 1'b1, "R5 7-bit no parity two stops");
    set_ctrl(5, 1'b0, 1'b0, 1'b1);
    frame(8'hED, 5, 1'b0, 1'b0, 1'b1, "R6 5-bit odd 1.5 stops");
    set_ctrl(6, 1'b0, 1'b1, 1'b1);
    frame(8'hF3, 6, 1'b0, 1'b1, 1'b1, "R5 6-bit even masked");
  endtask

  task automatic test_back_to_back();
    set_ctrl(6, 1'b0, 1'b1, 1'b0);
    write_and_start(8'h2C, "R7 first");
    fork
      begin
        repeat (20) @(negedge clk);
        tx_bus = 8'h13;
        load_n = 1'b0;
        repeat (2) @(negedge clk);
        load_n = 1'b1;
      end
    join_none
    check_body(8'h2C, 6, 1'b0, 1'b1, 1'b0, 1'b1, "R7 first");
    chk(hold_empty == 1'b1, "R7 holding freed at chain", int'(hold_empty), 1);
    check_body(8'h13, 6, 1'b0, 1'b1, 1'b0, 1'b0, "R7 second");
    repeat (5) @(negedge clk);
  endtask

  task automatic test_ctrl_ignored();
    set_ctrl(8, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    word_sel = 2'd0;
    par_off = 1'b0;
    par_even = 1'b1;
    stop_two = 1'b1;
    frame(8'h5A, 8, 1'b1, 1'b0, 1'b0, "R8 format inputs ignored");
  endtask

  task automatic test_reset_mid_frame();
    write_and_start(8'h00, "R9 before reset");
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R9 line low mid frame", int'(txd), 0);
    rst = 1'b1;
    #1;
    chk(txd == 1'b1, "R9 txd forced high", int'(txd), 1);
    chk(hold_empty == 1'b1 && shift_empty == 1'b1, "R9 flags set by reset",
        int'(shift_empty), 1);
    @(negedge clk);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    chk(txd == 1'b1, "R9 frame abandoned", int'(txd), 1);
    chk(shift_empty == 1'b1, "R9 shifter stays empty", int'(shift_empty), 1);
    frame(8'h4E, 5, 1'b0, 1'b0, 1'b0, "R9 format cleared by reset");
  endtask

  initial begin
    fork
      begin
        #(PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    join_none
    repeat (2) @(negedge clk);
    test_reset_state();
    test_default_format();
    test_formats();
    test_back_to_back();
    test_ctrl_ignored();
    test_reset_mid_frame();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule